// File: doc/BRIEF.md
# Modulus Counter Timer Channel

This channel is a free-running time base. A counter steps on a count event and compares itself against a programmable limit register. On a match it either wraps back to zero or turns around. Its live value is driven out so that other channels can share it as a time base. A sticky flag tells software that the limit was reached.

A count event is either a prescaler tick or a selected edge of an already filtered external pin. Up-only counting has two zeroing policies:
- zero-on-hit replaces the limit value with zero in the same update;
- zero-after-hit shows the limit value for one full count period and then returns to zero.

Up/down counting bounces between zero and the limit instead. Software can rewrite the limit at any time, and the new value is used from the next cycle on.

Top module: `mcnt_timer`

## Requirements
- R1: After reset the counter, the flag and the limit register are all zero, and the counting direction is up.
- R2: With `src_ext_i`=0 only `tick_i` pulses produce count events and pin edges are ignored. With `src_ext_i`=1 only pin edges produce count events and `tick_i` is ignored.
- R3: With the external source, `edge_both_i`=1 makes every pin transition a count event. With `edge_both_i`=0, `edge_rise_i`=1 selects rising (0→1) transitions only, and `edge_rise_i`=0 selects falling (1→0) transitions only.
- R4: The counter changes only on the clock edge that follows a cycle holding a count event. The update is visible one clock later.
- R5: In up mode (`updown_i`=0) with zero-on-hit (`clr_end_i`=0), an event whose incremented value equals the limit loads zero and sets the flag. With the external source, the next event then gives 1.
- R6: In up mode with zero-on-hit and the internal source, the first tick after the zeroing keeps the counter at 0. The tick after that gives 1.
- R7: In up mode with zero-after-hit (`clr_end_i`=1), an event that reaches the limit loads the limit and sets the flag. The next event loads zero, and the one after that gives 1.
- R8: In up/down mode (`updown_i`=1), counting turns downward on reaching the limit, which sets the flag. It turns upward again on reaching zero, which does not set the flag.
- R9: The flag stays set until a cycle with `flag_clr_i`=1 clears it. When a hit and a clear fall in the same cycle, the flag ends up set.
- R10: A write to the limit is used from the next cycle. A counter already above the new limit keeps counting up, wraps from all ones to zero, and then hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler tick, one cycle per tick |
| ext_pin_i | input | 1 | Filtered external count input |
| src_ext_i | input | 1 | 0: prescaler ticks, 1: external pin edges |
| updown_i | input | 1 | 0: up only, 1: up/down |
| clr_end_i | input | 1 | Up mode: 0 zero-on-hit, 1 zero-after-hit |
| edge_both_i | input | 1 | Count on both pin edges |
| edge_rise_i | input | 1 | Single-edge polarity: 1 rising, 0 falling |
| a1_we_i | input | 1 | Limit register write strobe |
| a1_wdata_i | input | CNT_W | Limit register write data |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| cnt_o | output | CNT_W | Live counter value |
| flag_o | output | 1 | Sticky match flag |

## Verification
Two things can land in the same cycle: a hit that sets the flag and a software clear that drops it. The bench steers the counter to one step below the limit. It then raises the tick and the clear strobe together and expects the flag to read set afterwards, with the counter at zero. A second clear alone must then drop the flag. A limit write that lands just before the event that would have hit is also checked, to confirm that the new limit governs that event.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } mcnt_dir_e;

  typedef struct packed {
    logic src_ext;
    logic updown;
    logic clr_end;
    logic edge_both;
    logic edge_rise;
  } mcnt_cfg_t;

endpackage

// File: rtl/mcnt_evsel.sv
module mcnt_evsel
  import mcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mcnt_cfg_t  cfg_i,
  input  logic       tick_i,
  input  logic       pin_i,
  output logic       ev_o
);

  logic pin_q;
  logic rise, fall, pin_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  always_comb begin
    rise   = pin_i & ~pin_q;
    fall   = ~pin_i & pin_q;
    if (cfg_i.edge_both)      pin_ev = rise | fall;
    else if (cfg_i.edge_rise) pin_ev = rise;
    else                      pin_ev = fall;
    ev_o = cfg_i.src_ext ? pin_ev : tick_i;
  end

endmodule

// File: rtl/mcnt_core.sv
module mcnt_core
  import mcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mcnt_cfg_t        cfg_i,
  input  logic             ev_i,
  input  logic [CNT_W-1:0] a1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_n, up_v, dn_v;
  mcnt_dir_e        dir_q, dir_n;
  logic             hold_q, hold_n, hit_raw;

  always_comb begin
    up_v    = step_up(cnt_q);
    dn_v    = step_dn(cnt_q);
    cnt_n   = up_v;
    dir_n   = dir_q;
    hold_n  = 1'b0;
    hit_raw = 1'b0;
    if (cfg_i.updown) begin
      if (dir_q == DIR_UP) begin
        hit_raw = (up_v == a1_i);
        if (hit_raw) dir_n = DIR_DN;
      end else begin
        cnt_n = dn_v;
        if (dn_v == ZERO) dir_n = DIR_UP;
      end
    end else if (cfg_i.clr_end) begin
      dir_n = DIR_UP;
      if (cnt_q == a1_i) cnt_n = ZERO;
      else               hit_raw = (up_v == a1_i);
    end else begin
      dir_n = DIR_UP;
      if (hold_q) begin
        cnt_n = ZERO;
      end else if (up_v == a1_i) begin
        cnt_n   = ZERO;
        hit_raw = 1'b1;
        hold_n  = ~cfg_i.src_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      dir_q  <= DIR_UP;
      hold_q <= 1'b0;
    end else if (ev_i) begin
      cnt_q  <= cnt_n;
      dir_q  <= dir_n;
      hold_q <= hold_n;
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = ev_i & hit_raw;

endmodule

// File: rtl/mcnt_flag.sv
module mcnt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/mcnt_timer.sv
module mcnt_timer
  import mcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ext_pin_i,
  input  logic             src_ext_i,
  input  logic             updown_i,
  input  logic             clr_end_i,
  input  logic             edge_both_i,
  input  logic             edge_rise_i,
  input  logic             a1_we_i,
  input  logic [CNT_W-1:0] a1_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);

  mcnt_cfg_t        cfg;
  logic             cnt_ev;
  logic             hit;
  logic [CNT_W-1:0] a1_q;

  assign cfg = '{src_ext:   src_ext_i,
                 updown:    updown_i,
                 clr_end:   clr_end_i,
                 edge_both: edge_both_i,
                 edge_rise: edge_rise_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       a1_q <= '0;
    else if (a1_we_i) a1_q <= a1_wdata_i;
  end

  mcnt_evsel u_evsel (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_i  (cfg),
    .tick_i (tick_i),
    .pin_i  (ext_pin_i),
    .ev_o   (cnt_ev)
  );

  mcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_i (cfg),
    .ev_i  (cnt_ev),
    .a1_i  (a1_q),
    .cnt_o (cnt_o),
    .hit_o (hit)
  );

  mcnt_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

endmodule

// File: rtl/mcnt_chk.sv
module mcnt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_ev,
  input logic             hit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] a1,
  input logic             flag,
  input logic             flag_clr,
  input logic             updown,
  input logic             clr_end
);

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ev |=> $stable(cnt)); // R4

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !updown && !clr_end |=> cnt == '0); // R5

  AST_END_SHOWS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !updown && clr_end |=> cnt == $past(a1)); // R7

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R9

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flag && flag_clr && !hit |=> !flag); // R9

  AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit)); // R9

endmodule

bind mcnt_timer mcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_ev   (cnt_ev),
  .hit      (hit),
  .cnt      (cnt_o),
  .a1       (a1_q),
  .flag     (flag_o),
  .flag_clr (flag_clr_i),
  .updown   (updown_i),
  .clr_end  (clr_end_i)
);

// File: tb/test_mcnt_timer.sv
`timescale 1ns/100ps
module test_mcnt_timer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, pin = 1'b0;
  logic         src_ext = 1'b0, updown = 1'b0, clr_end = 1'b0;
  logic         ebot = 1'b0, erise = 1'b1;
  logic         a1_we = 1'b0, fclr = 1'b0;
  logic [W-1:0] a1_wd = '0;
  logic [W-1:0] cnt;
  logic         flag;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mcnt_timer #(.CNT_W(W)) i_mcnt_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_pin_i(pin),
    .src_ext_i(src_ext), .updown_i(updown), .clr_end_i(clr_end),
    .edge_both_i(ebot), .edge_rise_i(erise), .a1_we_i(a1_we),
    .a1_wdata_i(a1_wd), .flag_clr_i(fclr), .cnt_o(cnt), .flag_o(flag)
  );

  // {src_ext, updown, clr_end, events, expected cnt, expected flag}, limit 5
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'd3,  8'd3, 1'b0},
    {1'b0, 1'b0, 1'b0, 8'd5,  8'd0, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'd6,  8'd0, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'd7,  8'd1, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'd4,  8'd4, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'd5,  8'd0, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'd6,  8'd1, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'd5,  8'd5, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'd6,  8'd0, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'd7,  8'd1, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'd7,  8'd3, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'd10, 8'd0, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'd11, 8'd1, 1'b1},
    {1'b1, 1'b0, 1'b1, 8'd6,  8'd0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; pin = 1'b0; a1_we = 1'b0; fclr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_limit(input int v);
    a1_we = 1'b1; a1_wd = W'(v);
    @(negedge clk);
    a1_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      pin = ~pin;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 flag", int'(flag), 0);
    ticks(3);
    chk("R1 limit zero wraps", int'(cnt), 3);

    // table walk: R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      string tag;
      src_external: begin
        src_ext = VEC[v][19]; updown = VEC[v][18]; clr_end = VEC[v][17];
        ebot = 1'b1;
      end
      do_reset();
      set_limit(5);
      if (src_ext) toggles(int'(VEC[v][16:9]));
      else         ticks(int'(VEC[v][16:9]));
      tag = updown ? "R8" : clr_end ? "R7" : src_ext ? "R5" : "R6";
      chk($sformatf("%s vec%0d cnt", tag, v), int'(cnt), int'(VEC[v][8:1]));
      chk($sformatf("%s vec%0d flag", tag, v), int'(flag), int'(VEC[v][0]));
    end

    // R2 source selection
    src_ext = 1'b1; updown = 1'b0; clr_end = 1'b0; ebot = 1'b1;
    do_reset(); set_limit(20);
    ticks(3);
    chk("R2 ticks ignored when external", int'(cnt), 0);
    src_ext = 1'b0;
    toggles(3);
    chk("R2 pin ignored when internal", int'(cnt), 0);
    ticks(2);
    chk("R2 ticks counted", int'(cnt), 2);

    // R3 edge selection
    src_ext = 1'b1; ebot = 1'b0; erise = 1'b1;
    do_reset(); set_limit(20);
    toggles(1);
    chk("R3 rising counted", int'(cnt), 1);
    toggles(1);
    chk("R3 falling ignored in rise mode", int'(cnt), 1);
    erise = 1'b0;
    do_reset(); set_limit(20);
    toggles(1);
    chk("R3 rising ignored in fall mode", int'(cnt), 0);
    toggles(1);
    chk("R3 falling counted", int'(cnt), 1);

    // R4 no change without events
    src_ext = 1'b0;
    do_reset(); set_limit(20);
    ticks(2);
    repeat (4) @(negedge clk);
    chk("R4 idle hold", int'(cnt), 2);

    // R9 hit and clear together, then clear alone
    do_reset(); set_limit(5);
    ticks(4);
    chk("R9 before hit flag", int'(flag), 0);
    tick = 1'b1; fclr = 1'b1;
    @(negedge clk);
    tick = 1'b0; fclr = 1'b0;
    chk("R9 set wins flag", int'(flag), 1);
    chk("R9 set wins cnt", int'(cnt), 0);
    ticks(3);
    chk("R9 sticky", int'(flag), 1);
    fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
    chk("R9 cleared", int'(flag), 0);

    // R10 limit write takes effect immediately
    do_reset(); set_limit(5);
    ticks(2);
    set_limit(3);
    ticks(1);
    chk("R10 new limit hit cnt", int'(cnt), 0);
    chk("R10 new limit hit flag", int'(flag), 1);

    // R10 counter above new limit wraps through all ones
    do_reset(); set_limit(10);
    ticks(4);
    set_limit(2);
    ticks(253);
    chk("R10 wrapped cnt", int'(cnt), 1);
    chk("R10 no early flag", int'(flag), 0);
    ticks(1);
    chk("R10 wrap hit cnt", int'(cnt), 0);
    chk("R10 wrap hit flag", int'(flag), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule